// File: doc/BRIEF.md
# Edge-Triggered Position Synchronizer with Capture

This block keeps the actual value of an incremental position axis and ties it to an external reference line. When the synchronizing mode is active, a low-to-high change on the reference line reloads the actual value with a fixed zero-offset constant. The same change makes the most recently supplied target position number active. A high-to-low change copies the actual value into a final-value register. That capture raises a done flag and an interrupt pulse. If the previous capture was never read, it also raises an overwrite flag and pulses its interrupt.

Counting goes on in every mode, so the compare of actual against target keeps driving the range flags, the direction flag and the two channel outputs. The mode is entered on a rising edge of the mode-select input. Entry invalidates the active target until the next synchronizing edge. If the reference line is already high at entry, no synchronization takes place and the next falling edge is ignored. Outside the mode, a written position number takes effect at once.

Top module: `edge_sync_capture`

## Requirements
- R1: With the mode active, a rising edge on `in_sig` sets `act_val` to ZERO_OFFSET (40 by default) and sets `sync_flag`; both are visible 3 clock edges after `in_sig` changes.
- R2: On that rising edge the pending position number becomes active, with target = number × POS_STEP (8 by default). From then on: `rng[0]` is act<target, `rng[1]` is act==target and `rng[2]` is act>target; `dir_flag` is 1 when act<=target; `chan_out[0]` equals `rng[0]` and `chan_out[1]` equals `rng[2]`.
- R3: With the mode active, a falling edge on `in_sig` copies the actual value into `fin_val`, sets `done_flag` and pulses `irq_done` high for one cycle, 3 clock edges after `in_sig` changes.
- R4: A capture while `done_flag` is still set, with no read strobe in that cycle, sets `ovw_flag` and pulses `irq_ovw` for one cycle.
- R5: A 0-to-1 change of `mode_sel` clears `sync_flag`, sets `rng` to 3'b111 and `dir_flag` to 1, and drives `chan_out` to 0, one edge later. Holding `mode_sel` at 1 has no further effect.
- R6: A position number written while the mode is active, or in the cycle of entry, stays pending: `rng`, `dir_flag` and `chan_out` do not change until the next synchronizing rising edge.
- R7: Setting `mode_sel` back to 0 leaves `sync_flag`, `act_val` and `fin_val` as they are; later `in_sig` edges then neither reload nor capture.
- R8: If `in_sig` is already high when the mode is entered, no synchronization occurs and the next falling edge of `in_sig` is not captured.
- R9: `act_val` increments by one per cycle with `cnt_up` alone and decrements with `cnt_dn` alone, wrapping modulo 2^AW. It holds when both or neither are set, and counting continues while the mode is active.
- R10: A `rd_strobe` cycle clears `done_flag` and `ovw_flag`. A read in the same cycle as a capture counts as reading the old value, so no overwrite is flagged.
- R11: A capture in a cycle that also counts stores the value from before that count step.
- R12: `irq_pos` is high for exactly the first cycle in which a valid target equals the actual value.
- R13: Outside the mode, a `pos_wr` cycle makes `pos_num` the active, valid target one edge later.
- R14: After reset, `act_val` and `fin_val` are 0, all flags are 0 except `rng` = 3'b111 and `dir_flag` = 1, and `chan_out` and the interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sig | input | 1 | External reference line, asynchronous |
| mode_sel | input | 1 | Synchronizing mode select, acts on its rising edge |
| pos_wr | input | 1 | Position number write strobe |
| pos_num | input | PW | Position number |
| cnt_up | input | 1 | Count up one step |
| cnt_dn | input | 1 | Count down one step |
| rd_strobe | input | 1 | Marks the final value as read |
| act_val | output | AW | Actual value |
| fin_val | output | AW | Final (captured) value |
| sync_flag | output | 1 | Synchronization done |
| rng | output | 3 | Range flags above/at/below |
| dir_flag | output | 1 | Direction flag |
| done_flag | output | 1 | Capture done |
| ovw_flag | output | 1 | Unread capture overwritten |
| chan_out | output | 2 | Channel outputs |
| irq_pos | output | 1 | Target-reached interrupt pulse |
| irq_done | output | 1 | Capture interrupt pulse |
| irq_ovw | output | 1 | Overwrite interrupt pulse |

## Verification
Effects of `in_sig` edges are due 3 edges after the line changes: two synchronizer stages plus the acting register. The bench's edge task therefore drives at a falling clock edge, waits three rising edges and samples at the next falling edge, where the one-cycle interrupt pulses are still high. Mode entry, reads, position writes and count steps act on the first rising edge after they are driven, and the compare outputs follow the registers without delay. They are sampled one falling edge after that. The count-during-capture case keeps counting on and predicts the value present just before the third edge.

// File: rtl/esc_pkg.sv
package esc_pkg;

  typedef struct packed {
    logic above;
    logic at;
    logic below;
  } rng_t;

  localparam rng_t RNG_INVALID = '{above: 1'b1, at: 1'b1, below: 1'b1};

endpackage

// File: rtl/esc_in_sync.sv
module esc_in_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic lvl,
  output logic rise,
  output logic fall
);

  logic st1_q, st2_q, st3_q;
  logic st1_d, st2_d, st3_d;

  always_comb begin
    st1_d = raw_in;
    st2_d = st1_q;
    st3_d = st2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= 1'b0;
      st2_q <= 1'b0;
      st3_q <= 1'b0;
    end else begin
      st1_q <= st1_d;
      st2_q <= st2_d;
      st3_q <= st3_d;
    end
  end

  assign lvl  = st2_q;
  assign rise = st2_q & ~st3_q;
  assign fall = ~st2_q & st3_q;

endmodule

// File: rtl/esc_counter.sv
module esc_counter #(
  parameter int AW          = 10,
  parameter int ZERO_OFFSET = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up,
  input  logic          dn,
  input  logic          load,
  output logic [AW-1:0] value
);

  localparam logic [AW-1:0] ZO = AW'(ZERO_OFFSET);

  logic [AW-1:0] val_q, val_d;
  logic          val_en;

  always_comb begin
    val_en = load | (up ^ dn);
    val_d  = val_q;
    if (load)
      val_d = ZO;
    else if (up && !dn)
      val_d = val_q + AW'(1);
    else if (dn && !up)
      val_d = val_q - AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      val_q <= '0;
    else if (val_en)
      val_q <= val_d;
  end

  assign value = val_q;

endmodule

// File: rtl/esc_capture.sv
module esc_capture #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          rd,
  input  logic [AW-1:0] act,
  output logic [AW-1:0] fin,
  output logic          done,
  output logic          ovw,
  output logic          irq_done,
  output logic          irq_ovw
);

  logic [AW-1:0] fin_q;
  logic          done_q, done_d;
  logic          ovw_q, ovw_d;
  logic          irqd_q, irqd_d;
  logic          irqo_q, irqo_d;
  logic          lost;

  always_comb begin
    lost   = take & done_q & ~rd;
    done_d = done_q;
    ovw_d  = ovw_q;
    if (rd) begin
      done_d = 1'b0;
      ovw_d  = 1'b0;
    end
    if (take) begin
      done_d = 1'b1;
      if (lost)
        ovw_d = 1'b1;
    end
    irqd_d = take;
    irqo_d = lost;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fin_q <= '0;
    else if (take)
      fin_q <= act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ovw_q  <= 1'b0;
      irqd_q <= 1'b0;
      irqo_q <= 1'b0;
    end else begin
      done_q <= done_d;
      ovw_q  <= ovw_d;
      irqd_q <= irqd_d;
      irqo_q <= irqo_d;
    end
  end

  assign fin      = fin_q;
  assign done     = done_q;
  assign ovw      = ovw_q;
  assign irq_done = irqd_q;
  assign irq_ovw  = irqo_q;

endmodule

// File: rtl/esc_ctrl.sv
module esc_ctrl
  import esc_pkg::*;
#(
  parameter int AW       = 10,
  parameter int PW       = 3,
  parameter int POS_STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          pos_wr,
  input  logic [PW-1:0] pos_num,
  input  logic          in_lvl,
  input  logic          in_rise,
  input  logic          in_fall,
  input  logic [AW-1:0] act,
  output logic          ev_rise,
  output logic          ev_fall,
  output logic          mode_rise,
  output logic          mode_on,
  output logic          pos_valid,
  output logic [PW-1:0] pos_act,
  output logic          sync_flag,
  output rng_t          rng,
  output logic          dir_flag,
  output logic [1:0]    chan_out,
  output logic          irq_pos
);

  localparam int TW = AW + PW + 8;

  logic          mprev_q;
  logic          mon_q, mon_d;
  logic          ign_q, ign_d;
  logic          sync_q, sync_d;
  logic          val_q, val_d;
  logic [PW-1:0] pend_q, pend_d;
  logic [PW-1:0] pact_q, pact_d;
  logic          reach_q, reach;
  logic          direct_wr;
  logic [TW-1:0] tgt_full;
  logic [TW-1:0] act_full;

  // mode edge and event qualification
  always_comb begin
    mode_rise = mode_sel & ~mprev_q;
    ev_rise   = mon_q & in_rise;
    ev_fall   = mon_q & in_fall & ~ign_q;
    direct_wr = pos_wr & ~mon_q & ~mode_rise;

    mon_d = mon_q;
    if (mode_rise)
      mon_d = 1'b1;
    else if (!mode_sel)
      mon_d = 1'b0;

    ign_d = ign_q;
    if (mode_rise)
      ign_d = in_lvl;
    else if (mon_q && in_fall)
      ign_d = 1'b0;

    sync_d = sync_q;
    if (mode_rise)
      sync_d = 1'b0;
    else if (ev_rise)
      sync_d = 1'b1;

    pend_d = pos_wr ? pos_num : pend_q;

    val_d  = val_q;
    pact_d = pact_q;
    if (mode_rise) begin
      val_d = 1'b0;
    end else if (ev_rise) begin
      val_d  = 1'b1;
      pact_d = pend_q;
    end else if (direct_wr) begin
      val_d  = 1'b1;
      pact_d = pos_num;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mprev_q <= 1'b0;
      mon_q   <= 1'b0;
      ign_q   <= 1'b0;
      sync_q  <= 1'b0;
      val_q   <= 1'b0;
      reach_q <= 1'b0;
    end else begin
      mprev_q <= mode_sel;
      mon_q   <= mon_d;
      ign_q   <= ign_d;
      sync_q  <= sync_d;
      val_q   <= val_d;
      reach_q <= reach;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= '0;
    else if (pos_wr)
      pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pact_q <= '0;
    else if (ev_rise || direct_wr)
      pact_q <= pact_d;
  end

  // target compare and output drive
  always_comb begin
    tgt_full = TW'(pact_q) * TW'(POS_STEP);
    act_full = TW'(act);
    if (val_q) begin
      rng.below = act_full < tgt_full;
      rng.at    = act_full == tgt_full;
      rng.above = act_full > tgt_full;
      dir_flag  = act_full <= tgt_full;
      chan_out  = {rng.above, rng.below};
    end else begin
      rng      = RNG_INVALID;
      dir_flag = 1'b1;
      chan_out = 2'b00;
    end
    reach   = val_q & (act_full == tgt_full);
    irq_pos = reach & ~reach_q;
  end

  assign mode_on   = mon_q;
  assign pos_valid = val_q;
  assign pos_act   = pact_q;
  assign sync_flag = sync_q;

endmodule

// File: rtl/edge_sync_capture.sv
module edge_sync_capture
  import esc_pkg::*;
#(
  parameter int AW          = 10,
  parameter int PW          = 3,
  parameter int POS_STEP    = 8,
  parameter int ZERO_OFFSET = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_sig,
  input  logic          mode_sel,
  input  logic          pos_wr,
  input  logic [PW-1:0] pos_num,
  input  logic          cnt_up,
  input  logic          cnt_dn,
  input  logic          rd_strobe,
  output logic [AW-1:0] act_val,
  output logic [AW-1:0] fin_val,
  output logic          sync_flag,
  output logic [2:0]    rng,
  output logic          dir_flag,
  output logic          done_flag,
  output logic          ovw_flag,
  output logic [1:0]    chan_out,
  output logic          irq_pos,
  output logic          irq_done,
  output logic          irq_ovw
);

  logic          in_lvl, in_rise, in_fall;
  logic          ev_rise, ev_fall, mode_rise, mode_on, pos_valid;
  logic [PW-1:0] pos_act;
  rng_t          rng_s;

  esc_in_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (in_sig),
    .lvl    (in_lvl),
    .rise   (in_rise),
    .fall   (in_fall)
  );

  esc_counter #(.AW(AW), .ZERO_OFFSET(ZERO_OFFSET)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .up    (cnt_up),
    .dn    (cnt_dn),
    .load  (ev_rise),
    .value (act_val)
  );

  esc_capture #(.AW(AW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (ev_fall),
    .rd       (rd_strobe),
    .act      (act_val),
    .fin      (fin_val),
    .done     (done_flag),
    .ovw      (ovw_flag),
    .irq_done (irq_done),
    .irq_ovw  (irq_ovw)
  );

  esc_ctrl #(.AW(AW), .PW(PW), .POS_STEP(POS_STEP)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .pos_wr    (pos_wr),
    .pos_num   (pos_num),
    .in_lvl    (in_lvl),
    .in_rise   (in_rise),
    .in_fall   (in_fall),
    .act       (act_val),
    .ev_rise   (ev_rise),
    .ev_fall   (ev_fall),
    .mode_rise (mode_rise),
    .mode_on   (mode_on),
    .pos_valid (pos_valid),
    .pos_act   (pos_act),
    .sync_flag (sync_flag),
    .rng       (rng_s),
    .dir_flag  (dir_flag),
    .chan_out  (chan_out),
    .irq_pos   (irq_pos)
  );

  assign rng = rng_s;

endmodule

// File: rtl/edge_sync_capture_chk.sv
module edge_sync_capture_chk #(
  parameter int AW          = 10,
  parameter int PW          = 3,
  parameter int ZERO_OFFSET = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_rise,
  input logic          ev_fall,
  input logic          mode_rise,
  input logic          mode_on,
  input logic          pos_valid,
  input logic [PW-1:0] pos_act,
  input logic          rd_strobe,
  input logic [AW-1:0] act_val,
  input logic [AW-1:0] fin_val,
  input logic          sync_flag,
  input logic [2:0]    rng,
  input logic          dir_flag,
  input logic          done_flag,
  input logic          ovw_flag,
  input logic [1:0]    chan_out,
  input logic          irq_done
);

  a_r1_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise |=> (act_val == AW'(ZERO_OFFSET)) && sync_flag);

  a_r2_range_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    pos_valid |-> ($countones(rng) == 1));

  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fall |=> (fin_val == $past(act_val)) && done_flag && irq_done);

  a_r3_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  a_r4_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fall && done_flag && !rd_strobe) |=> ovw_flag);

  a_r5_entry: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rise |=> !sync_flag && (rng == 3'b111) && dir_flag && (chan_out == 2'b00));

  a_r6_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_on && !ev_rise) |=> $stable(pos_act));

  a_r10_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !ev_fall) |=> !done_flag && !ovw_flag);

endmodule

bind edge_sync_capture edge_sync_capture_chk #(
  .AW(AW), .PW(PW), .ZERO_OFFSET(ZERO_OFFSET)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_rise   (ev_rise),
  .ev_fall   (ev_fall),
  .mode_rise (mode_rise),
  .mode_on   (mode_on),
  .pos_valid (pos_valid),
  .pos_act   (pos_act),
  .rd_strobe (rd_strobe),
  .act_val   (act_val),
  .fin_val   (fin_val),
  .sync_flag (sync_flag),
  .rng       (rng),
  .dir_flag  (dir_flag),
  .done_flag (done_flag),
  .ovw_flag  (ovw_flag),
  .chan_out  (chan_out),
  .irq_done  (irq_done)
);

// File: tb/edge_sync_capture_tb_top.sv
`timescale 1ns/1ps
module edge_sync_capture_tb_top;

  localparam int AW = 10;
  localparam int PW = 3;
  localparam int STEP = 8;
  localparam int ZO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_sig = 1'b0, mode_sel = 1'b0, pos_wr = 1'b0;
  logic [PW-1:0] pos_num = '0;
  logic cnt_up = 1'b0, cnt_dn = 1'b0, rd_strobe = 1'b0;
  logic [AW-1:0] act_val, fin_val;
  logic sync_flag, dir_flag, done_flag, ovw_flag, irq_pos, irq_done, irq_ovw;
  logic [2:0] rng;
  logic [1:0] chan_out;

  int checks = 0;
  int errors = 0;
  int exp_act = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  edge_sync_capture #(.AW(AW), .PW(PW), .POS_STEP(STEP), .ZERO_OFFSET(ZO)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_sig(in_sig), .mode_sel(mode_sel),
    .pos_wr(pos_wr), .pos_num(pos_num), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .rd_strobe(rd_strobe), .act_val(act_val), .fin_val(fin_val),
    .sync_flag(sync_flag), .rng(rng), .dir_flag(dir_flag),
    .done_flag(done_flag), .ovw_flag(ovw_flag), .chan_out(chan_out),
    .irq_pos(irq_pos), .irq_done(irq_done), .irq_ovw(irq_ovw)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_cmp(input string tag, input int a, input int tgt);
    int e_rng;
    e_rng = (a > tgt ? 4 : 0) | (a == tgt ? 2 : 0) | (a < tgt ? 1 : 0);
    chk({tag, " rng"}, int'(rng), e_rng);
    chk({tag, " dir"}, int'(dir_flag), (a <= tgt) ? 1 : 0);
    chk({tag, " chan"}, int'(chan_out), ((a > tgt) ? 2 : 0) | ((a < tgt) ? 1 : 0));
  endtask

  task automatic chk_invalid(input string tag);
    chk({tag, " rng"}, int'(rng), 7);
    chk({tag, " dir"}, int'(dir_flag), 1);
    chk({tag, " chan"}, int'(chan_out), 0);
  endtask

  // drive in_sig, result due 3 edges later
  task automatic drive_in(input logic v);
    @(negedge clk) in_sig = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic count(input int n, input bit up);
    if (n > 0) begin
      @(negedge clk);
      cnt_up = up;
      cnt_dn = !up;
      repeat (n) @(negedge clk);
      cnt_up = 1'b0;
      cnt_dn = 1'b0;
      exp_act = up ? (exp_act + n) % 1024 : (exp_act - n + 1024) % 1024;
    end
  endtask

  task automatic enter_mode(input logic wr, input int p);
    @(negedge clk);
    mode_sel = 1'b0;
    @(negedge clk);
    mode_sel = 1'b1;
    pos_wr = wr;
    pos_num = PW'(p);
    @(negedge clk);
    pos_wr = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14 reset state
    chk("R14 act", int'(act_val), 0);
    chk("R14 fin", int'(fin_val), 0);
    chk("R14 sync", int'(sync_flag), 0);
    chk("R14 done", int'(done_flag), 0);
    chk("R14 ovw", int'(ovw_flag), 0);
    chk("R14 irq", int'({irq_pos, irq_done, irq_ovw}), 0);
    chk_invalid("R14");

    // R9 counting, wrap and hold
    count(5, 1'b1);
    chk("R9 up", int'(act_val), exp_act);
    count(7, 1'b0);
    chk("R9 down wrap", int'(act_val), exp_act);
    @(negedge clk) begin cnt_up = 1'b1; cnt_dn = 1'b1; end
    repeat (4) @(negedge clk);
    cnt_up = 1'b0; cnt_dn = 1'b0;
    chk("R9 both hold", int'(act_val), exp_act);
    count(12, 1'b1);
    chk("R9 up back", int'(act_val), exp_act);

    // R13 direct write outside mode
    @(negedge clk) begin pos_wr = 1'b1; pos_num = 3'd2; end
    @(negedge clk) pos_wr = 1'b0;
    chk_cmp("R13 direct", exp_act, 16);
    chk("R12 no reach", int'(irq_pos), 0);

    // R5 / R6 / R1 / R2 / R3 sweep over all position numbers
    for (int p = 0; p < 8; p++) begin
      enter_mode(1'b1, p);
      chk("R5 sync clr", int'(sync_flag), 0);
      chk_invalid("R5 entry");
      count(3, 1'b1);
      chk("R9 count in mode", int'(act_val), exp_act);
      chk_invalid("R6 pending");
      drive_in(1'b1);
      exp_act = ZO;
      chk("R1 reload", int'(act_val), ZO);
      chk("R1 sync set", int'(sync_flag), 1);
      chk_cmp("R2 compare", ZO, p * STEP);
      chk("R12 irq_pos", int'(irq_pos), (ZO == p * STEP) ? 1 : 0);
      @(negedge clk);
      chk("R12 pulse end", int'(irq_pos), 0);
      count(p + 1, 1'b1);
      chk_cmp("R2 after count", exp_act, p * STEP);
      drive_in(1'b0);
      chk("R3 fin", int'(fin_val), exp_act);
      chk("R3 done", int'(done_flag), 1);
      chk("R3 irq", int'(irq_done), 1);
      chk("R4 no ovw", int'(ovw_flag), 0);
      @(negedge clk);
      chk("R3 irq pulse", int'(irq_done), 0);
      do_read();
      chk("R10 done clr", int'(done_flag), 0);
    end

    // R4 overwrite
    drive_in(1'b1);
    exp_act = ZO;
    count(2, 1'b1);
    drive_in(1'b0);
    chk("R4 first cap", int'(done_flag), 1);
    drive_in(1'b1);
    exp_act = ZO;
    count(4, 1'b0);
    drive_in(1'b0);
    chk("R4 ovw", int'(ovw_flag), 1);
    chk("R4 irq_ovw", int'(irq_ovw), 1);
    chk("R4 fin", int'(fin_val), exp_act);
    @(negedge clk);
    chk("R4 irq pulse", int'(irq_ovw), 0);
    do_read();
    chk("R10 ovw clr", int'(ovw_flag), 0);
    chk("R10 done clr2", int'(done_flag), 0);

    // R10 read in the capture cycle, R11 count during capture
    drive_in(1'b1);
    exp_act = ZO;
    drive_in(1'b0);
    drive_in(1'b1);
    exp_act = ZO;
    @(negedge clk) begin in_sig = 1'b0; cnt_up = 1'b1; end
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) rd_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk) begin rd_strobe = 1'b0; cnt_up = 1'b0; end
    chk("R10 same cycle done", int'(done_flag), 1);
    chk("R10 same cycle ovw", int'(ovw_flag), 0);
    chk("R11 fin pre-count", int'(fin_val), ZO + 2);
    chk("R11 act", int'(act_val), ZO + 3);
    exp_act = ZO + 3;
    do_read();

    // R7 exit keeps state, later edges ignored
    @(negedge clk) mode_sel = 1'b0;
    @(negedge clk);
    chk("R7 sync kept", int'(sync_flag), 1);
    drive_in(1'b1);
    chk("R7 no reload", int'(act_val), exp_act);
    drive_in(1'b0);
    chk("R7 no capture", int'(done_flag), 0);
    chk("R7 fin kept", int'(fin_val), ZO + 2);

    // R8 line high at entry
    @(negedge clk) in_sig = 1'b1;
    repeat (4) @(negedge clk);
    enter_mode(1'b1, 3);
    repeat (4) @(negedge clk);
    chk("R8 no sync", int'(sync_flag), 0);
    chk("R8 act kept", int'(act_val), exp_act);
    drive_in(1'b0);
    chk("R8 fall ignored", int'(done_flag), 0);
    chk("R8 irq none", int'(irq_done), 0);
    drive_in(1'b1);
    chk("R8 later sync", int'(sync_flag), 1);
    chk_cmp("R8 later compare", ZO, 24);
    drive_in(1'b0);
    chk("R8 later capture", int'(done_flag), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule